// File: doc/BRIEF.md
# Bit Set/Clear Read-Modify-Write Sequencer

This block runs the single-bit set and clear instructions of a small 8-bit processor. When the block is idle and the caller presents an opcode in the bit-operation family together with the address of that opcode, the block owns the bus for four cycles. In the first cycle it reads the one-byte direct operand that follows the opcode. In the second cycle it reads the target byte, and it raises a read-modify-write qualifier on that read only. In the third cycle it writes the byte back to the same address with one bit forced. In the fourth cycle it fetches the byte of the next instruction.

The RMW qualifier lets peripherals tell the read half of a bit operation from an ordinary load. A port can then return its output latch instead of its pin levels, and an interrupt flag can return 1 so that a write-back of another bit does not clear it. The bus is a simple synchronous memory port: the address and strobes come from registers inside the block, and read data returns in the same cycle.

Top module: `bitop_rmw_seq`

## Requirements
- R1: Opcodes 0xA0 to 0xA7 (bit 3 = 0) clear the bit selected by opcode[2:0] in the target byte. The other seven bits are written back unchanged.
- R2: Opcodes 0xA8 to 0xAF (bit 3 = 1) set the bit selected by opcode[2:0]. The other seven bits are written back unchanged.
- R3: In the first busy cycle, addr_o equals pc_i+1, with rd_o=1, wr_o=0 and rmw_o=0. The rdata_i byte of that cycle becomes the direct address.
- R4: In the second busy cycle, addr_o holds the direct byte zero-extended to 16 bits, with rd_o=1, rmw_o=1 and wr_o=0.
- R5: In the third busy cycle, addr_o keeps the same direct address, with wr_o=1, rd_o=0 and rmw_o=0. wdata_o carries the modified byte.
- R6: In the fourth busy cycle, addr_o equals pc_i+2 with rd_o=1, wr_o=0 and rmw_o=0. The rdata_i byte of that cycle appears on next_op_o from the following cycle on.
- R7: busy_o is high for exactly the four bus cycles. done_o is high only in the fourth cycle, for one cycle.
- R8: start_i is ignored while busy_o is high. The running operation keeps its opcode and addresses.
- R9: start_i with an opcode outside 0xA0 to 0xAF is ignored. The block stays idle with all strobes low.
- R10: After reset the block is idle: rd_o, wr_o, rmw_o, busy_o and done_o are 0, and addr_o, wdata_o and next_op_o are 0.
- R11: rd_o and wr_o are never high together, and rmw_o is never high without rd_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run the opcode on opcode_i |
| opcode_i | input | 8 | Opcode byte |
| pc_i | input | 16 | Address of the opcode byte |
| rdata_i | input | 8 | Read data from the bus, valid in the same cycle |
| addr_o | output | 16 | Bus address |
| wdata_o | output | 8 | Write data, valid while wr_o is high |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| rmw_o | output | 1 | Qualifier marking the read of the target byte |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | High in the last cycle of a sequence |
| next_op_o | output | 8 | Byte fetched in the fourth cycle |

## Verification
The bench runs set and clear operations on bit 0, on bit 7 and on middle bits. It uses target bytes of 0x00, 0xFF and mixed patterns, so it can see both a bit that really changes and a bit that is already in the requested state. All-ones and all-zeros bytes reveal any disturbance of a neighbouring bit. A clear on a byte that already has the bit clear shows whether set and clear are swapped. Different program counters, including one whose low byte carries into the high byte, and different direct addresses separate the four address phases. A foreign opcode and a start request during a running sequence check that the block ignores requests it should not accept.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OPND  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_NEXT  = 3'd4
  } seq_state_e;

  localparam logic [3:0] OP_FAMILY = 4'hA;

  function automatic logic is_bitop(input logic [7:0] op);
    return op[7:4] == OP_FAMILY;
  endfunction
endpackage

// File: rtl/bitop_fsm.sv
module bitop_fsm
  import bitop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_i) state_d = ST_OPND;
      ST_OPND:  state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_NEXT;
      ST_NEXT:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign state_o = state_q;
endmodule

// File: rtl/bitop_modify.sv
module bitop_modify #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              set_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign data_o[b] = (idx_i == IDX_W'(b)) ? set_i : data_i[b];
  end
endmodule

// File: rtl/bitop_addr.sv
module bitop_addr
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  seq_state_e        state_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] dir_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    unique case (state_i)
      ST_OPND:           addr_o = pc_i + ADDR_W'(1);
      ST_READ, ST_WRITE: addr_o = ADDR_W'(dir_i);
      ST_NEXT:           addr_o = pc_i + ADDR_W'(2);
      default:           addr_o = '0;
    endcase
  end
endmodule

// File: rtl/bitop_rmw_seq.sv
module bitop_rmw_seq
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              rmw_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        next_op_o
);
  seq_state_e        state;
  logic              accept;
  logic [7:0]        op_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] dir_q, wbuf_q, modified;

  assign accept = (state == ST_IDLE) && start_i && is_bitop(opcode_i);

  bitop_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .state_o (state)
  );

  bitop_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .state_i(state),
    .pc_i   (pc_q),
    .dir_i  (dir_q),
    .addr_o (addr_o)
  );

  bitop_modify #(.DATA_W(DATA_W)) u_mod (
    .data_i(rdata_i),
    .idx_i (op_q[IDX_W-1:0]),
    .set_i (op_q[IDX_W]),
    .data_o(modified)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= '0;
      pc_q      <= '0;
      dir_q     <= '0;
      wbuf_q    <= '0;
      next_op_o <= '0;
    end else begin
      if (accept) begin
        op_q <= opcode_i;
        pc_q <= pc_i;
      end
      if (state == ST_OPND) dir_q     <= rdata_i;
      if (state == ST_READ) wbuf_q    <= modified;
      if (state == ST_NEXT) next_op_o <= rdata_i[7:0];
    end
  end

  assign rd_o    = (state == ST_OPND) || (state == ST_READ) || (state == ST_NEXT);
  assign wr_o    = (state == ST_WRITE);
  assign rmw_o   = (state == ST_READ);
  assign busy_o  = (state != ST_IDLE);
  assign done_o  = (state == ST_NEXT);
  assign wdata_o = wr_o ? wbuf_q : '0;
endmodule

// File: rtl/bitop_rmw_chk.sv
module bitop_rmw_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic [DATA_W-1:0] rdata_i,
  input logic              rd_o,
  input logic              wr_o,
  input logic              rmw_o,
  input logic              busy_o,
  input logic              done_o
);
  assert_rd_wr_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  assert_rmw_is_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmw_o |-> rd_o && !wr_o);
  assert_first_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> rd_o && !rmw_o && !wr_o);
  assert_write_after_rmw_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(rmw_o) && addr_o == $past(addr_o));
  assert_one_bit_changed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $countones(wdata_o ^ $past(rdata_i)) <= 1);
  assert_done_after_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_o) && busy_o);
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind bitop_rmw_seq bitop_rmw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_o (addr_o),
  .wdata_o(wdata_o),
  .rdata_i(rdata_i),
  .rd_o   (rd_o),
  .wr_o   (wr_o),
  .rmw_o  (rmw_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/bitop_rmw_seq_bench.sv
module bitop_rmw_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic [7:0]  wdata, next_op;
  logic        rd, wr, rmw, busy, done;

  int checks = 0;
  int fails = 0;

  logic [7:0]  dmem [256];
  logic [15:0] code_pc = 16'h0100;
  logic [7:0]  code_opnd = '0;
  logic [7:0]  code_next = '0;

  always #10 clk = ~clk;

  bitop_rmw_seq u_bitop_rmw_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode), .pc_i(pc),
    .rdata_i(rdata), .addr_o(addr), .wdata_o(wdata), .rd_o(rd), .wr_o(wr),
    .rmw_o(rmw), .busy_o(busy), .done_o(done), .next_op_o(next_op)
  );

  always_comb begin
    if (!rd)                      rdata = 8'h00;
    else if (addr[15:8] == 8'h00) rdata = dmem[addr[7:0]];
    else if (addr == code_pc + 16'd1) rdata = code_opnd;
    else if (addr == code_pc + 16'd2) rdata = code_next;
    else                          rdata = 8'h00;
  end

  always @(posedge clk) if (wr && addr[15:8] == 8'h00) dmem[addr[7:0]] <= wdata;

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobes(input string req, input logic [2:0] exp_rwm);
    chk(req, {29'd0, rd, wr, rmw}, {29'd0, exp_rwm});
  endtask

  // Runs one bit operation and checks each bus cycle (R3..R7, R1/R2 result)
  task automatic run_op(input logic [7:0] op, input logic [15:0] p, input logic [7:0] dir,
                        input logic [7:0] init, input logic [7:0] nxt, input logic poke);
    logic [7:0] exp;
    exp = op[3] ? (init | (8'h1 << op[2:0])) : (init & ~(8'h1 << op[2:0]));
    dmem[dir] = init;
    code_pc = p; code_opnd = dir; code_next = nxt;
    @(negedge clk);
    start = 1'b1; opcode = op; pc = p;
    @(negedge clk);
    if (poke) begin opcode = 8'hA8; pc = 16'h0000; end else start = 1'b0;
    chk("R3 addr", {16'd0, addr}, {16'd0, p + 16'd1});
    strobes("R3 strobes", 3'b100);
    chk("R7 busy c1", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk("R4 addr", {16'd0, addr}, {24'd0, dir});
    strobes("R4 strobes", 3'b101);
    @(negedge clk);
    chk("R5 addr", {16'd0, addr}, {24'd0, dir});
    strobes("R5 strobes", 3'b010);
    chk(op[3] ? "R2 wdata" : "R1 wdata", {24'd0, wdata}, {24'd0, exp});
    chk("R7 no done c3", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R6 addr", {16'd0, addr}, {16'd0, p + 16'd2});
    strobes("R6 strobes", 3'b100);
    chk("R7 done c4", {31'd0, done}, 32'd1);
    start = 1'b0;
    @(negedge clk);
    chk(op[3] ? "R2 mem" : "R1 mem", {24'd0, dmem[dir]}, {24'd0, exp});
    chk("R6 next_op", {24'd0, next_op}, {24'd0, nxt});
    chk("R7 idle after", {30'd0, busy, done}, 32'd0);
    if (poke) chk("R8 no restart", {29'd0, rd, wr, rmw}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R10 strobes", {27'd0, rd, wr, rmw, busy, done}, 32'd0);
    chk("R10 addr", {16'd0, addr}, 32'd0);
    chk("R10 wdata/next", {16'd0, wdata, next_op}, 32'd0);
  endtask

  task automatic t_foreign(input logic [7:0] op);
    @(negedge clk);
    start = 1'b1; opcode = op; pc = 16'h0300;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 ignored", {27'd0, rd, wr, rmw, busy, done}, 32'd0);
    end
    start = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_op(8'hA0, 16'h0100, 8'h40, 8'hFF, 8'h12, 1'b0); // R1 clear bit0
    run_op(8'hA7, 16'h0200, 8'h41, 8'hA5, 8'h34, 1'b0); // R1 clear bit7
    run_op(8'hA3, 16'h0250, 8'h42, 8'h00, 8'h56, 1'b0); // R1 already clear
    run_op(8'hAF, 16'h12FE, 8'h80, 8'h00, 8'h78, 1'b0); // R2 set bit7, pc carry
    run_op(8'hA8, 16'h0400, 8'hFF, 8'h5A, 8'h9A, 1'b0); // R2 set bit0
    run_op(8'hAC, 16'h0500, 8'h07, 8'hFF, 8'hBC, 1'b0); // R2 already set
    t_foreign(8'h9F);                                   // R9
    t_foreign(8'hB0);                                   // R9
    run_op(8'hA2, 16'h0600, 8'h33, 8'hF0, 8'hDE, 1'b1); // R8 start held busy
    chk("R8 other byte untouched", {24'd0, dmem[8'h00]}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule